// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic read and write an external asynchronous static RAM with a 19-bit address and an 8-bit data bus. A request arrives on a valid/ready handshake with an address, a write flag and write data. The controller then produces the active-low chip select, write strobe and output-enable strobe, the address, and a tristate data bus. Read data returns with a one-cycle valid pulse.

The memory's timing minimums are given in nanoseconds for three speed grades (10, 12 and 15 ns). `CLK_PERIOD_NS` and `GRADE_NS` convert them into whole clock counts at elaboration. For each grade the values are: write pulse with output enable high 8/8/9 ns, data setup before the strobe rises 5/6/7 ns, output-enable access 5/6/7 ns, and cycle, access and write-cycle time 10/12/15 ns.

During a write the controller keeps output enable high, so the shorter write pulse applies. It ends every write by raising the write strobe while chip select is still low. Every access is followed by at least one idle cycle in standby. This gives the bus a turnaround gap between a read and the next write.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, write strobe and output enable are high, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only in the idle state. `req_ready` is low in every cycle of an access, and each accepted handshake produces exactly one memory access.
- R3: A write keeps chip select low for its whole length. It has one set-up cycle with the write strobe high, then the write strobe low for WP = max(ceil(twp/P), ceil(tds/P)) cycles, and the write strobe then rises while chip select is still low. Here P = `CLK_PERIOD_NS`, twp = 8/8/9 ns and tds = 5/6/7 ns for grades 10/12/15.
- R4: Address and write data stay constant from the cycle the write strobe falls through the cycle after it rises. The memory stores the requested data at the requested address.
- R5: Chip select stays low for a write for max(WP+2, ceil(twc/P)) cycles, where twc = 10/12/15 ns.
- R6: A read holds chip select and output enable low, with the write strobe high, for RD = max(ceil(taa/P), ceil(toe/P)) cycles, where taa = 10/12/15 ns and toe = 5/6/7 ns. The data bus is sampled at the clock edge that ends this window.
- R7: `rsp_valid` goes high for exactly one cycle, RD+1 clock cycles after the edge that accepted the read, and `rsp_rdata` carries the sampled byte.
- R8: Between two accesses chip select is high for at least one full cycle, with the data bus released. While `req_ready` is high all three strobes are high.
- R9: The write strobe is never low while output enable is low, and the controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Memory address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Byte returned by a read |
| sram_addr | output | 19 | Address pins of the memory |
| sram_dq | inout | 8 | Bidirectional data pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The bench runs the controller as if its clock period were 4 ns at the 15 ns grade, so every minimum spans several cycles. Its memory model returns inverted data until the required number of access cycles has passed. A controller that samples a read one edge early therefore returns wrong bytes, and one that shortens the write pulse or the chip-select window fails the cycle counts taken at every strobe edge. Writes and reads are interleaved, with reads directly followed by writes, to catch a missing idle cycle or a write strobe that overlaps output enable. Addresses are spread over the upper bits, so a truncated address shows up as aliased data on read-back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSET   = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WTAIL  = 3'd3,
        ST_RACC   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Write pulse minimum when output enable stays high
    function automatic int grade_twp(input int grade);
        case (grade)
            10:      return 8;
            12:      return 8;
            default: return 9;
        endcase
    endfunction

    // Data setup before the write strobe rises
    function automatic int grade_tds(input int grade);
        case (grade)
            10:      return 5;
            12:      return 6;
            default: return 7;
        endcase
    endfunction

    // Output-enable access time
    function automatic int grade_toe(input int grade);
        case (grade)
            10:      return 5;
            12:      return 6;
            default: return 7;
        endcase
    endfunction

    // Read cycle, address access and write cycle time
    function automatic int grade_tcyc(input int grade);
        case (grade)
            10:      return 10;
            12:      return 12;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.cnt = load_val;
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done = (cur_q.cnt == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done); // R3

    AST_TIMER_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cur_q.cnt == $past(cur_q.cnt) - 1'b1)); // R6

endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 2,
    parameter int RD_CYC   = 1,
    parameter int WP_CYC   = 1,
    parameter int TAIL_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             req_ready,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output pin_ctl_t         pins_d
);

    typedef struct packed {
        seq_state_e state;
    } fsm_t;

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_CYC - 1);

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        nxt_d.state = ST_WSET;
                    end else begin
                        nxt_d.state = ST_RACC;
                        timer_load  = 1'b1;
                        timer_val   = RD_LOAD;
                    end
                end
            end
            ST_WSET: begin
                nxt_d.state = ST_WPULSE;
                timer_load  = 1'b1;
                timer_val   = WP_LOAD;
            end
            ST_WPULSE: begin
                if (timer_done) begin
                    nxt_d.state = ST_WTAIL;
                    timer_load  = 1'b1;
                    timer_val   = TAIL_LOAD;
                end
            end
            ST_WTAIL: begin
                if (timer_done) begin
                    nxt_d.state = ST_IDLE;
                end
            end
            ST_RACC: begin
                if (timer_done) begin
                    capture     = 1'b1;
                    nxt_d.state = ST_IDLE;
                end
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase

        pins_d.ce_n  = (nxt_d.state == ST_IDLE);
        pins_d.we_n  = (nxt_d.state != ST_WPULSE);
        pins_d.oe_n  = (nxt_d.state != ST_RACC);
        pins_d.drive = (nxt_d.state == ST_WSET) || (nxt_d.state == ST_WPULSE) ||
                       (nxt_d.state == ST_WTAIL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.state == ST_IDLE);

    AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.state == ST_WPULSE) |-> ($past(cur_q.state) == ST_WSET)); // R3

    AST_TAIL_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.state == ST_WTAIL) |-> ($past(cur_q.state) == ST_WPULSE)); // R3

    AST_ONE_ACCESS_PER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R2

endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_ctl_t          pins_d,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        pin_ctl_t          pins;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } io_t;

    io_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.pins   = pins_d;
        nxt_d.rvalid = capture;
        if (accept) begin
            nxt_d.addr  = req_addr;
            nxt_d.wdata = req_wdata;
        end
        if (capture) begin
            nxt_d.rdata = sram_dq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.pins   <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            cur_q.addr   <= '0;
            cur_q.wdata  <= '0;
            cur_q.rdata  <= '0;
            cur_q.rvalid <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sram_dq   = cur_q.pins.drive ? cur_q.wdata : {DATA_W{1'bz}};
    assign sram_addr = cur_q.addr;
    assign sram_ce_n = cur_q.pins.ce_n;
    assign sram_we_n = cur_q.pins.we_n;
    assign sram_oe_n = cur_q.pins.oe_n;
    assign rsp_valid = cur_q.rvalid;
    assign rsp_rdata = cur_q.rdata;

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.pins.ce_n && $past(!cur_q.pins.ce_n)) |-> $stable(cur_q.addr)); // R4

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.pins.drive && $past(cur_q.pins.drive)) |-> $stable(cur_q.wdata)); // R4

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.pins.drive |-> cur_q.pins.oe_n); // R9

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.rvalid |=> !cur_q.rvalid); // R7

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int GRADE_NS      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);

    localparam int T_WP     = grade_twp(GRADE_NS);
    localparam int T_DS     = grade_tds(GRADE_NS);
    localparam int T_OE     = grade_toe(GRADE_NS);
    localparam int T_CYC    = grade_tcyc(GRADE_NS);
    localparam int WP_CYC   = max2(ceil_div(T_WP, CLK_PERIOD_NS), ceil_div(T_DS, CLK_PERIOD_NS));
    localparam int WC_CYC   = ceil_div(T_CYC, CLK_PERIOD_NS);
    localparam int TAIL_CYC = max2(1, WC_CYC - WP_CYC - 1);
    localparam int RD_CYC   = max2(ceil_div(T_CYC, CLK_PERIOD_NS), ceil_div(T_OE, CLK_PERIOD_NS));
    localparam int MAX_CYC  = max2(RD_CYC, max2(WP_CYC, TAIL_CYC));
    localparam int CNT_W    = max2(1, $clog2(MAX_CYC + 1));

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             accept;
    logic             capture;
    pin_ctl_t         pins_d;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_access_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .TAIL_CYC (TAIL_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ready  (req_ready),
        .timer_done (timer_done),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .accept     (accept),
        .capture    (capture),
        .pins_d     (pins_d)
    );

    sram_pin_stage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_d    (pins_d),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sram_addr (sram_addr),
        .sram_ce_n (sram_ce_n),
        .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n),
        .sram_dq   (sram_dq),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n); // R3

    AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> !sram_ce_n); // R3

    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n)); // R9

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n)); // R8

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

    localparam int CFG_P     = 4;
    localparam int CFG_GRADE = 15;
    // Grade-15 minimums from the requirements: twp 9, tds 7, toe 7, cycle 15
    localparam int EXP_WP  = ((9 + CFG_P - 1) / CFG_P > (7 + CFG_P - 1) / CFG_P) ?
                             (9 + CFG_P - 1) / CFG_P : (7 + CFG_P - 1) / CFG_P;
    localparam int EXP_WC  = (15 + CFG_P - 1) / CFG_P;
    localparam int EXP_WIN = (EXP_WP + 2 > EXP_WC) ? EXP_WP + 2 : EXP_WC;
    localparam int EXP_RD  = ((15 + CFG_P - 1) / CFG_P > (7 + CFG_P - 1) / CFG_P) ?
                             (15 + CFG_P - 1) / CFG_P : (7 + CFG_P - 1) / CFG_P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] sram_addr;
    wire  [7:0]  sram_dq;
    logic        sram_ce_n, sram_we_n, sram_oe_n;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W        (19),
        .DATA_W        (8),
        .CLK_PERIOD_NS (CFG_P),
        .GRADE_NS      (CFG_GRADE)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .sram_addr (sram_addr),
        .sram_dq   (sram_dq),
        .sram_ce_n (sram_ce_n),
        .sram_we_n (sram_we_n),
        .sram_oe_n (sram_oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [logic [18:0]];
    logic [7:0] sb  [logic [18:0]];
    bit         mon_en = 1'b0;
    int         acc_cnt = 0;
    logic [7:0] model_val = '0;
    logic       model_drv;

    assign model_drv = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq   = model_drv ? model_val : 8'bz;

    function automatic logic [7:0] mem_rd(input logic [18:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge sram_we_n) begin
        if (mon_en && !sram_ce_n) mem[sram_addr] = sram_dq;
    end

    always @(negedge clk) begin
        if (model_drv) acc_cnt = acc_cnt + 1;
        else acc_cnt = 0;
        model_val = (acc_cnt >= EXP_RD) ? mem_rd(sram_addr) : ~mem_rd(sram_addr);
    end

    // ---------------- pin monitor ----------------
    bit          p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    int          win = 0, hi_cnt = 1, we_cnt = 0, oe_cnt = 0;
    bit          win_wr = 1'b0;
    logic [7:0]  lat_dq = '0;
    logic [18:0] lat_a = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!sram_ce_n) begin
                if (p_ce) begin
                    chk(hi_cnt >= 1, "R8 idle gap", hi_cnt, 1);
                    win = 1;
                    win_wr = 1'b0;
                end else begin
                    win++;
                end
            end else begin
                if (!p_ce) begin
                    if (win_wr) chk(win == EXP_WIN, "R5 write window", win, EXP_WIN);
                    else        chk(win == EXP_RD, "R6 read window", win, EXP_RD);
                    hi_cnt = 1;
                end else begin
                    hi_cnt++;
                end
            end
            if (!sram_we_n) begin
                chk(sram_oe_n == 1'b1, "R9 oe during write", sram_oe_n, 1);
                if (p_we) begin
                    win_wr = 1'b1;
                    chk(win == 2, "R3 setup cycle", win, 2);
                    we_cnt = 1;
                    lat_dq = sram_dq;
                    lat_a  = sram_addr;
                end else begin
                    we_cnt++;
                    chk(sram_dq == lat_dq, "R4 data stable", sram_dq, lat_dq);
                    chk(sram_addr == lat_a, "R4 addr stable", sram_addr, lat_a);
                end
            end else if (!p_we) begin
                chk(we_cnt == EXP_WP, "R3 pulse width", we_cnt, EXP_WP);
                chk(sram_ce_n == 1'b0, "R3 ce low at we rise", sram_ce_n, 0);
                chk(sram_dq == lat_dq, "R4 data hold", sram_dq, lat_dq);
                chk(sram_addr == lat_a, "R4 addr hold", sram_addr, lat_a);
            end
            if (!sram_oe_n) begin
                chk(sram_we_n == 1'b1, "R6 we high in read", sram_we_n, 1);
                oe_cnt = p_oe ? 1 : oe_cnt + 1;
            end else if (!p_oe) begin
                chk(oe_cnt == EXP_RD, "R6 oe width", oe_cnt, EXP_RD);
            end
            if (req_ready) begin
                chk(sram_ce_n && sram_we_n && sram_oe_n, "R8 idle strobes",
                    {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
            end
            p_ce = sram_ce_n;
            p_we = sram_we_n;
            p_oe = sram_oe_n;
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        sb[a] = d;
    endtask

    task automatic do_read(input logic [18:0] a);
        int lat;
        logic [7:0] exp;
        exp = sb.exists(a) ? sb[a] : 8'h00;
        issue(1'b0, a, 8'h00);
        lat = 1;
        while (!rsp_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == EXP_RD + 1, "R7 read latency", lat, EXP_RD + 1);
        chk(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 single pulse", rsp_valid, 0);
    endtask

    function automatic logic [18:0] addr_of(input int i);
        return 19'((i * 32'h13579) ^ (i << 12));
    endfunction

    function automatic logic [7:0] data_of(input int i);
        return 8'(i * 37 + 5);
    endfunction

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk({sram_ce_n, sram_we_n, sram_oe_n} == 3'b111, "R1 strobes in reset",
            {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sram_ce_n, sram_we_n, sram_oe_n} == 3'b111, "R1 strobes after reset",
            {sram_ce_n, sram_we_n, sram_oe_n}, 3'b111);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
        mon_en = 1'b1;

        // Sweep writes across spread addresses, then read back (R4, R6)
        for (int i = 0; i < 24; i++) do_write(addr_of(i), data_of(i));
        for (int i = 0; i < 24; i++) do_read(addr_of(i));

        // Read immediately followed by write, then read back (R8, R9)
        for (int i = 0; i < 12; i++) begin
            do_read(addr_of(i));
            do_write(addr_of(i + 40), ~data_of(i));
            do_read(addr_of(i + 40));
        end

        // Overwrite the same location, and read never-written cells
        do_write(19'h7FFFF, 8'h11);
        do_write(19'h7FFFF, 8'hEE);
        do_read(19'h7FFFF);
        do_write(19'h00000, 8'hFF);
        do_read(19'h00000);
        do_read(19'h40001);

        // Single-bit addresses to expose aliasing (R4)
        for (int b = 0; b < 19; b++) do_write(19'(1) << b, 8'(b + 8'h80));
        for (int b = 0; b < 19; b++) do_read(19'(1) << b);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule